// File: doc/BRIEF.md
# Serial Converter Host Sequencer

This block is the master side of a link to an external 8-bit multiplexed analog-to-digital converter. The converter has a synchronous serial port and no end-of-conversion pin. A client hands the block a 4-bit channel number over a valid/ready handshake. The block lowers the converter's select line and waits a setup interval. It then runs exactly eight serial-clock pulses. During those pulses it drives the channel number out MSB first and gathers the eight bits the converter sends back.

The word read during an exchange is the result of the conversion the previous exchange started. The block therefore labels each returned word with the channel number of that earlier request. It withholds the result of the very first exchange after reset, because that word comes from no conversion. After the eighth falling serial-clock edge the select line goes high at once. It stays high for a computed window that covers the converter's longest conversion time, and only then can a new request be taken.

Channel numbers 12 to 15 would put the converter into a test mode. Such requests are consumed and flagged as rejected, and no exchange starts.

Top module: `sadc_host`

## Requirements
- R1: After reset, adc_cs_n is high, adc_sclk is low, busy is low, req_ready is high, and rsp_valid and req_reject are low.
- R2: req_ready is high exactly when busy is low. A handshake (req_valid and req_ready) with req_chan from 0 to 11 pulls adc_cs_n low and raises busy on the following clock.
- R3: A handshake with req_chan from 12 to 15 raises req_reject for exactly one clock on the following cycle. adc_cs_n stays high and busy stays low.
- R4: Each exchange has exactly eight high pulses on adc_sclk. Each high phase lasts SCLK_HALF clocks and each low phase between pulses lasts SCLK_HALF clocks. The first rising edge comes SETUP_CLKS + SCLK_HALF clocks after adc_cs_n falls. adc_sclk is never high while adc_cs_n is high.
- R5: adc_din carries the 8-bit frame {channel[3:0], 4'b0000}, MSB first. Each bit is set up during a low phase and does not change across the following rising edge.
- R6: adc_dout is sampled on the clock of each rising serial-clock edge. The first sample is the result MSB, and the eighth sample is the LSB.
- R7: adc_cs_n goes high on the same clock as the eighth falling edge of adc_sclk.
- R8: After each exchange, adc_cs_n stays high and busy stays high for exactly (64 + 1) × CONV_RATIO clocks. This covers 64 converter-clock periods plus one, which is also more than three.
- R9: rsp_valid pulses for one clock, on the clock adc_cs_n rises. rsp_data is the word read in that exchange, and rsp_chan is the channel accepted in the exchange before it. The first exchange after reset gives no pulse.
- R10: busy is high from the clock adc_cs_n falls until the post-conversion window ends, and adc_cs_n is never low while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_chan | input | 4 | Requested channel number |
| req_ready | output | 1 | Request can be taken (block idle) |
| req_reject | output | 1 | One-clock pulse: last taken request had an illegal channel |
| rsp_valid | output | 1 | One-clock pulse: result available |
| rsp_chan | output | 4 | Channel the result belongs to |
| rsp_data | output | 8 | Conversion result |
| busy | output | 1 | Exchange or post-conversion wait in progress |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_din | output | 1 | Serial address to converter |
| adc_dout | input | 1 | Serial result from converter |

## Verification
The bench builds the block with SCLK_HALF = 2, SETUP_CLKS = 3 and CONV_RATIO = 2. That gives a 130-clock wait and an exchange of about 170 clocks. With these values every legal channel can be swept in both directions, and every illegal channel can be tried, well within the run limit. A converter model in the bench returns channel × 37 plus a running conversion index. Because of that index, a result tagged with the wrong channel or taken from the wrong exchange gives a word that does not match. Cycle counts of the setup, each phase and the wait are compared with the formulas in the requirements, so an off-by-one in any timer is visible.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LO,
    ST_HI,
    ST_WAIT
  } sadc_state_e;

  localparam int unsigned FRAME_BITS    = 8;
  localparam int unsigned ADDR_BITS     = 4;
  localparam int unsigned DATA_BITS     = 8;
  localparam int unsigned CONV_MAX_CYC  = 64;
  localparam int unsigned CS_HI_MIN_CYC = 3;
  localparam int unsigned CHAN_LIMIT    = 12;

  // System clocks adc_cs_n must stay high after the eighth falling edge:
  // the longer of the conversion time and the select-recognition time,
  // plus one converter clock of margin.
  function automatic int unsigned cs_wait_clks(int unsigned ratio);
    int unsigned cyc;
    cyc = CONV_MAX_CYC;
    if (CS_HI_MIN_CYC + 1 > cyc) cyc = CS_HI_MIN_CYC + 1;
    return (cyc + 1) * ratio;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  function automatic logic chan_legal(logic [ADDR_BITS-1:0] ch);
    return 32'(ch) < CHAN_LIMIT;
  endfunction

endpackage

// File: rtl/sadc_timer.sv
module sadc_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
  parameter int unsigned FRAME = 8,
  parameter int unsigned ABITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_tx,
  input  logic [ABITS-1:0] chan,
  input  logic             shift_tx,
  input  logic             sample_rx,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [FRAME-1:0] rx_word
);
  localparam int unsigned PAD = FRAME - ABITS;

  logic [FRAME-1:0] tx_q;
  logic [FRAME-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_q <= '0;
    else if (load_tx)   tx_q <= {chan, {PAD{1'b0}}};
    else if (shift_tx)  tx_q <= {tx_q[FRAME-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_q <= '0;
    else if (sample_rx) rx_q <= {rx_q[FRAME-2:0], ser_in};
  end

  assign ser_out = tx_q[FRAME-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int unsigned TMR_W      = 8,
  parameter int unsigned SCLK_HALF  = 8,
  parameter int unsigned SETUP_CLKS = 4,
  parameter int unsigned WAIT_CLKS  = 130
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             expire,
  output sadc_state_e      state,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  output logic             ev_rise,
  output logic             ev_fall,
  output logic             ev_last_fall
);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  sadc_state_e    state_q, state_d;
  logic [BIT_W-1:0] bit_q;

  always_comb begin
    state_d      = state_q;
    tmr_load     = 1'b0;
    tmr_val      = '0;
    ev_rise      = 1'b0;
    ev_fall      = 1'b0;
    ev_last_fall = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SETUP_CLKS - 1);
      end
      ST_SETUP: if (expire) begin
        state_d  = ST_LO;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SCLK_HALF - 1);
      end
      ST_LO: if (expire) begin
        state_d  = ST_HI;
        ev_rise  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SCLK_HALF - 1);
      end
      ST_HI: if (expire) begin
        ev_fall  = 1'b1;
        tmr_load = 1'b1;
        if (bit_q == LAST_BIT) begin
          ev_last_fall = 1'b1;
          state_d      = ST_WAIT;
          tmr_val      = TMR_W'(WAIT_CLKS - 1);
        end else begin
          state_d = ST_LO;
          tmr_val = TMR_W'(SCLK_HALF - 1);
        end
      end
      ST_WAIT: if (expire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start && state_q == ST_IDLE) bit_q <= '0;
      else if (ev_fall)                bit_q <= bit_q + 1'b1;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/sadc_host.sv
module sadc_host
  import sadc_pkg::*;
#(
  parameter int unsigned SCLK_HALF  = 8,
  parameter int unsigned SETUP_CLKS = 4,
  parameter int unsigned CONV_RATIO = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_BITS-1:0] req_chan,
  output logic                 req_ready,
  output logic                 req_reject,
  output logic                 rsp_valid,
  output logic [ADDR_BITS-1:0] rsp_chan,
  output logic [DATA_BITS-1:0] rsp_data,
  output logic                 busy,
  output logic                 adc_cs_n,
  output logic                 adc_sclk,
  output logic                 adc_din,
  input  logic                 adc_dout
);
  localparam int unsigned WAIT_CLKS = cs_wait_clks(CONV_RATIO);
  localparam int unsigned TMR_MAX   = max3(WAIT_CLKS, SETUP_CLKS, SCLK_HALF);
  localparam int unsigned TMR_W     = $clog2(TMR_MAX + 1);

  // Named internal events, visible to the bound checker
  sadc_state_e          state;
  logic                 ev_take, ev_accept, ev_reject;
  logic                 ev_rise, ev_fall, ev_last_fall;
  logic                 tmr_load, tmr_expire;
  logic [TMR_W-1:0]     tmr_val;
  logic [FRAME_BITS-1:0] rx_word;

  logic [ADDR_BITS-1:0] cur_chan_q, prev_chan_q;
  logic                 prev_ok_q;
  logic                 rsp_valid_q, reject_q;
  logic [ADDR_BITS-1:0] rsp_chan_q;
  logic [DATA_BITS-1:0] rsp_data_q;

  assign req_ready = (state == ST_IDLE);
  assign ev_take   = req_valid && req_ready;
  assign ev_accept = ev_take && chan_legal(req_chan);
  assign ev_reject = ev_take && !chan_legal(req_chan);

  sadc_seq #(
    .TMR_W      (TMR_W),
    .SCLK_HALF  (SCLK_HALF),
    .SETUP_CLKS (SETUP_CLKS),
    .WAIT_CLKS  (WAIT_CLKS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (ev_accept),
    .expire       (tmr_expire),
    .state        (state),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .ev_rise      (ev_rise),
    .ev_fall      (ev_fall),
    .ev_last_fall (ev_last_fall)
  );

  sadc_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  sadc_shift #(.FRAME(FRAME_BITS), .ABITS(ADDR_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_tx   (ev_accept),
    .chan      (req_chan),
    .shift_tx  (ev_fall),
    .sample_rx (ev_rise),
    .ser_in    (adc_dout),
    .ser_out   (adc_din),
    .rx_word   (rx_word)
  );

  // Result tagging: the word read now belongs to the previous request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_chan_q  <= '0;
      prev_chan_q <= '0;
      prev_ok_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_chan_q  <= '0;
      rsp_data_q  <= '0;
      reject_q    <= 1'b0;
    end else begin
      reject_q    <= ev_reject;
      rsp_valid_q <= 1'b0;
      if (ev_accept) cur_chan_q <= req_chan;
      if (ev_last_fall) begin
        rsp_valid_q <= prev_ok_q;
        rsp_chan_q  <= prev_chan_q;
        rsp_data_q  <= rx_word[DATA_BITS-1:0];
        prev_chan_q <= cur_chan_q;
        prev_ok_q   <= 1'b1;
      end
    end
  end

  assign req_reject = reject_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_chan   = rsp_chan_q;
  assign rsp_data   = rsp_data_q;
  assign busy       = (state != ST_IDLE);
  assign adc_cs_n   = (state == ST_IDLE) || (state == ST_WAIT);
  assign adc_sclk   = (state == ST_HI);
endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk #(
  parameter int unsigned WAIT_CLKS = 130
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] req_chan,
  input logic       req_reject,
  input logic       rsp_valid,
  input logic       busy,
  input logic       adc_cs_n,
  input logic       adc_sclk,
  input logic       adc_din,
  input logic       ev_last_fall
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_cnt <= 32'hFFFF_FFFF;
    else if (!adc_cs_n)         hi_cnt <= '0;
    else if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (adc_cs_n && !adc_sclk)); // R1
  AST_ACCEPT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_chan < 4'd12) |=> (!adc_cs_n && busy)); // R2
  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_chan >= 4'd12) |=> (req_reject && adc_cs_n && !busy)); // R3
  AST_SCLK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> !adc_cs_n); // R4
  AST_DIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sclk) |-> $stable(adc_din)); // R5
  AST_CS_AT_LAST_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_fall |=> (adc_cs_n && !adc_sclk)); // R7
  AST_CS_HIGH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> (hi_cnt >= WAIT_CLKS)); // R8
  AST_RSP_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(adc_cs_n)); // R9
  AST_RSP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> busy); // R10
endmodule

bind sadc_host sadc_host_chk #(.WAIT_CLKS(WAIT_CLKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_chan     (req_chan),
  .req_reject   (req_reject),
  .rsp_valid    (rsp_valid),
  .busy         (busy),
  .adc_cs_n     (adc_cs_n),
  .adc_sclk     (adc_sclk),
  .adc_din      (adc_din),
  .ev_last_fall (ev_last_fall)
);

// File: tb/test_sadc_host.sv
module test_sadc_host;
  localparam int HALF  = 2;
  localparam int SETUP = 3;
  localparam int RATIO = 2;
  localparam int WAITC = 65 * RATIO;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_chan = '0;
  logic       req_ready, req_reject, rsp_valid, busy;
  logic [3:0] rsp_chan;
  logic [7:0] rsp_data;
  logic       adc_cs_n, adc_sclk, adc_din, adc_dout;

  int checks = 0;
  int fails  = 0;
  logic [3:0] acc_ch [0:63];
  int acc_cnt = 0;
  int rsp_cnt = 0;

  always #10 clk = ~clk;

  sadc_host #(.SCLK_HALF(HALF), .SETUP_CLKS(SETUP), .CONV_RATIO(RATIO)) i_sadc_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_ready(req_ready), .req_reject(req_reject), .rsp_valid(rsp_valid),
    .rsp_chan(rsp_chan), .rsp_data(rsp_data), .busy(busy),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_dout(adc_dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Converter model: result = channel*37 + conversion index
  logic [7:0] m_sreg = '0, m_res = '0, m_addr = '0;
  logic       m_prev_sclk = 1'b0, m_prev_cs = 1'b1;
  int         m_falls = 0, m_conv = 0;

  assign adc_dout = m_sreg[7];

  always @(posedge clk) begin
    if (!adc_cs_n && m_prev_cs) begin
      m_sreg  <= m_res;
      m_falls <= 0;
    end else if (!adc_cs_n && adc_sclk && !m_prev_sclk) begin
      m_addr <= {m_addr[6:0], adc_din};
    end else if (!adc_sclk && m_prev_sclk) begin
      m_sreg  <= {m_sreg[6:0], 1'b0};
      m_falls <= m_falls + 1;
      if (m_falls == 7) begin
        // R5: frame is channel then four zero bits
        chk(m_addr == {acc_ch[m_conv], 4'h0}, "R5 address frame", m_addr, {acc_ch[m_conv], 4'h0});
        m_res  <= 8'(32'(m_addr[7:4]) * 37 + m_conv);
        m_conv <= m_conv + 1;
      end
    end
    m_prev_sclk <= adc_sclk;
    m_prev_cs   <= adc_cs_n;
  end

  // Timing monitor at the falling clock edge
  logic p_sclk = 1'b0, p_cs = 1'b1;
  int lead = 0, hi_n = 0, lo_n = 0, pulses = 0, wc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!adc_cs_n && p_cs) begin
        pulses = 0; lead = 1;
        chk(busy, "R10 busy at select fall", busy, 1);
      end else if (!adc_cs_n && !adc_sclk && pulses == 0) lead++;
      if (adc_sclk && !p_sclk) begin
        if (pulses == 0) chk(lead == SETUP + HALF, "R4 lead to first rise", lead, SETUP + HALF);
        else             chk(lo_n == HALF, "R4 low phase", lo_n, HALF);
        pulses++; hi_n = 1;
      end else if (adc_sclk) hi_n++;
      if (!adc_sclk && p_sclk) begin
        chk(hi_n == HALF, "R4 high phase", hi_n, HALF);
        lo_n = 1;
        if (pulses == 8) chk(adc_cs_n, "R7 select high at 8th fall", adc_cs_n, 1);
      end else if (!adc_sclk && !adc_cs_n && pulses > 0) lo_n++;
      if (adc_cs_n && !p_cs) chk(pulses == 8, "R4 pulse count", pulses, 8);
      if (adc_cs_n && busy) wc++;
      else if (!busy && wc > 0) begin
        chk(wc == WAITC, "R8 wait window", wc, WAITC);
        wc = 0;
      end
      if (!adc_cs_n && !busy) chk(0, "R10 select low while idle", 0, 1);
      if (rsp_valid) begin
        chk(rsp_cnt < acc_cnt - 1, "R9 response count", rsp_cnt, acc_cnt - 1);
        chk(adc_cs_n && !p_cs, "R9 response at select rise", adc_cs_n, 1);
        chk(rsp_chan == acc_ch[rsp_cnt], "R9 tag channel", rsp_chan, acc_ch[rsp_cnt]);
        chk(rsp_data == 8'(32'(acc_ch[rsp_cnt]) * 37 + rsp_cnt), "R6 result data",
            rsp_data, 8'(32'(acc_ch[rsp_cnt]) * 37 + rsp_cnt));
        rsp_cnt++;
      end
    end
    p_sclk = adc_sclk;
    p_cs   = adc_cs_n;
  end

  task automatic do_req(input logic [3:0] ch);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    chk(!busy, "R2 ready only when idle", busy, 0);
    req_valid = 1'b1;
    req_chan  = ch;
    if (ch < 4'd12) begin
      acc_ch[acc_cnt] = ch;
      acc_cnt++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (ch < 4'd12) begin
      chk(!adc_cs_n && busy && !req_ready, "R2 select after accept", adc_cs_n, 0);
      while (busy) @(negedge clk);
    end else begin
      chk(req_reject, "R3 reject pulse", req_reject, 1);
      chk(adc_cs_n && !busy, "R3 no exchange", adc_cs_n, 1);
      @(negedge clk);
      chk(!req_reject, "R3 reject one clock", req_reject, 0);
      for (int i = 0; i < 4; i++) begin
        chk(adc_cs_n && !busy, "R3 stays idle", adc_cs_n, 1);
        @(negedge clk);
      end
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(adc_cs_n,   "R1 cs_n high",   adc_cs_n, 1);
    chk(!adc_sclk,  "R1 sclk low",    adc_sclk, 0);
    chk(!busy,      "R1 busy low",    busy, 0);
    chk(req_ready,  "R1 ready high",  req_ready, 1);
    chk(!rsp_valid && !req_reject, "R1 pulses low", rsp_valid, 0);
    // first exchange yields no response (R9)
    do_req(4'd0);
    chk(rsp_cnt == 0, "R9 first exchange withheld", rsp_cnt, 0);
    for (int c = 1; c < 12; c++) do_req(4'(c));
    for (int c = 12; c < 16; c++) do_req(4'(c));
    for (int c = 11; c >= 0; c--) do_req(4'(c));
    repeat (10) @(negedge clk);
    chk(rsp_cnt == acc_cnt - 1, "R9 total responses", rsp_cnt, acc_cnt - 1);
    finish_run();
  end
endmodule